// File: doc/BRIEF.md
# RGB Panel Sync and Pixel Timing Generator

This block drives a direct-drive RGB display panel. It produces the horizontal sync, vertical sync, data-enable, pixel clock and chip-select lines, and it launches pixel data in step with the pixel clock. The active width and height, the front and back porches, the sync widths, the pixel clock period, the start delay, and the data setup and hold windows are all set on configuration inputs. Sizes and sync widths are given as value minus one.

Each line is a sequence of pixel slots: sync first, then back porch, then active pixels, then front porch. A frame is built from lines in the same order. A pixel slot lasts one pixel clock period. At the start of every active slot the block raises a request with the pixel's coordinates. A frame-buffer reader answers in the same cycle on `rgb_in`. The block holds that word and drives it on `rgb_out` inside a window around the pixel clock's active edge.

The configuration is expected to stay stable while `enable` is high. Dropping `enable` returns the block to idle. When `enable` rises again, the block restarts at the top of a frame after the start delay.

Top module: `tft_timing_gen`

## Requirements
- R1: While in reset or while disabled, every panel line sits at its inactive level, `rgb_out` is 0, `frame_start` is 0 and `pix_req` is 0.
- R2: Count the rising edges at which `enable` is sampled high without a break. Internal timing begins after edge number `start_pos`+1. The panel outputs show the first cycle of a frame after edge number `start_pos`+2 and stay inactive until then.
- R3: A pixel slot lasts L = `period` cycles, or 2 cycles when `period` is below 2. In each slot the pixel clock is inactive for the first floor(L/2) cycles and active for the remaining cycles. The inactive-to-active transition is the active edge.
- R4: A line has `h_sync_m1`+1 sync slots, then `h_bp` back-porch slots, then `h_act_m1`+1 active slots, then `h_fp` front-porch slots. Horizontal sync is active during the sync slots.
- R5: A frame has `v_sync_m1`+1 sync lines, then `v_bp`, then `v_act_m1`+1 active lines, then `v_fp`. Vertical sync is active for whole sync lines.
- R6: Data-enable is active for the whole of every slot that lies in both the horizontal and the vertical active region.
- R7: `pix_req` is high in the first cycle of each active slot, one cycle before the panel outputs show that slot. `pix_x` and `pix_y` hold the zero-based column and row at that time. `rgb_in` is sampled in that same cycle.
- R8: Within an active slot, with E = floor(L/2), `rgb_out` carries the sampled word in cycles max(E-`setup_cyc`,0) through min(E+`hold_cyc`,L-1) of the slot, counted from 0. At all other times it is 0.
- R9: `pol` bit 0 sets the sense of hsync, bit 1 vsync, bit 2 data-enable, bit 3 the pixel clock and bit 4 chip-select. A 1 means active-high and a 0 means active-low.
- R10: `frame_start` is a one-cycle active-high pulse in the first output cycle of each frame, which is the first cycle of vertical sync.
- R11: Chip-select is active in every output cycle from the first frame cycle until the block is disabled.
- R12: A rising edge with `enable` low returns the block to idle. A later enable restarts the start delay and begins again at the top of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Drive enable; low forces idle |
| h_act_m1 | input | SZ_W | Active width minus one |
| v_act_m1 | input | SZ_W | Active height minus one |
| h_fp | input | PORCH_W | Horizontal front porch in slots |
| h_bp | input | PORCH_W | Horizontal back porch in slots |
| v_fp | input | PORCH_W | Vertical front porch in lines |
| v_bp | input | PORCH_W | Vertical back porch in lines |
| h_sync_m1 | input | SYNC_W | Hsync width minus one |
| v_sync_m1 | input | SYNC_W | Vsync width minus one |
| period | input | CNT_W | Pixel clock period in internal cycles |
| start_pos | input | CNT_W | Start delay after enable |
| setup_cyc | input | WIN_W | Data lead before the active edge |
| hold_cyc | input | WIN_W | Data hold after the active edge |
| pol | input | 5 | Per-line polarity |
| rgb_in | input | RGB_W | Pixel word from the reader |
| pix_req | output | 1 | Pixel request |
| pix_x | output | SZ_W | Requested column |
| pix_y | output | SZ_W | Requested row |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data-enable |
| pclk | output | 1 | Pixel clock |
| cs | output | 1 | Panel chip-select |
| frame_start | output | 1 | Frame start pulse |
| rgb_out | output | RGB_W | Pixel data to panel |

## Verification
The bench builds the block with its default parameters: 16-bit pixels and the field widths described above. It then drives small geometries, such as frames of 54 slots and down to one-pixel active areas with zero porches, so that many complete frames fit in a short run. Across the runs it covers the slot-length clamp at 2, an odd period, setup and hold windows clamped at both ends of the slot, a nonzero start delay, mixed polarities, and re-enabling in the middle of a frame.

// File: rtl/tft_timing_gen.sv
module tft_timing_gen #(
  parameter int RGB_W   = 16,
  parameter int SZ_W    = 10,
  parameter int PORCH_W = 8,
  parameter int SYNC_W  = 7,
  parameter int CNT_W   = 11,
  parameter int WIN_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic [SZ_W-1:0]    h_act_m1,
  input  logic [SZ_W-1:0]    v_act_m1,
  input  logic [PORCH_W-1:0] h_fp,
  input  logic [PORCH_W-1:0] h_bp,
  input  logic [PORCH_W-1:0] v_fp,
  input  logic [PORCH_W-1:0] v_bp,
  input  logic [SYNC_W-1:0]  h_sync_m1,
  input  logic [SYNC_W-1:0]  v_sync_m1,
  input  logic [CNT_W-1:0]   period,
  input  logic [CNT_W-1:0]   start_pos,
  input  logic [WIN_W-1:0]   setup_cyc,
  input  logic [WIN_W-1:0]   hold_cyc,
  input  logic [4:0]         pol,
  input  logic [RGB_W-1:0]   rgb_in,
  output logic               pix_req,
  output logic [SZ_W-1:0]    pix_x,
  output logic [SZ_W-1:0]    pix_y,
  output logic               hsync,
  output logic               vsync,
  output logic               de,
  output logic               pclk,
  output logic               cs,
  output logic               frame_start,
  output logic [RGB_W-1:0]   rgb_out
);
  localparam int LINE_MAX = (1 << SYNC_W) + 2 * ((1 << PORCH_W) - 1) + (1 << SZ_W);
  localparam int POS_W    = $clog2(LINE_MAX + 1);

  logic             run;
  logic [CNT_W-1:0] dly_cnt, div_cnt;
  logic [POS_W-1:0] h_cnt, v_cnt;
  logic [RGB_W-1:0] pix_hold, rgb_q;
  logic             hs_q, vs_q, de_q, pclk_q, cs_q, fs_q;

  logic [CNT_W-1:0] slot_len, half, win_lo, win_hi, setup_x, hold_x;
  logic [POS_W-1:0] h_sy_end, h_act_beg, h_act_end, h_total;
  logic [POS_W-1:0] v_sy_end, v_act_beg, v_act_end, v_total;
  logic             in_h, in_v, slot_end, line_end, frame_end, in_win, slot_first;

  assign slot_len = (period < CNT_W'(2)) ? CNT_W'(2) : period;
  assign half     = slot_len >> 1;
  assign setup_x  = CNT_W'(setup_cyc);
  assign hold_x   = CNT_W'(hold_cyc);
  assign win_lo   = (half > setup_x) ? half - setup_x : '0;
  assign win_hi   = (slot_len - CNT_W'(1) - half > hold_x) ? half + hold_x : slot_len - CNT_W'(1);

  assign h_sy_end  = POS_W'(h_sync_m1) + POS_W'(1);
  assign h_act_beg = h_sy_end + POS_W'(h_bp);
  assign h_act_end = h_act_beg + POS_W'(h_act_m1) + POS_W'(1);
  assign h_total   = h_act_end + POS_W'(h_fp);
  assign v_sy_end  = POS_W'(v_sync_m1) + POS_W'(1);
  assign v_act_beg = v_sy_end + POS_W'(v_bp);
  assign v_act_end = v_act_beg + POS_W'(v_act_m1) + POS_W'(1);
  assign v_total   = v_act_end + POS_W'(v_fp);

  assign in_h       = (h_cnt >= h_act_beg) && (h_cnt < h_act_end);
  assign in_v       = (v_cnt >= v_act_beg) && (v_cnt < v_act_end);
  assign slot_first = (div_cnt == '0);
  assign slot_end   = (div_cnt == slot_len - CNT_W'(1));
  assign line_end   = (h_cnt == h_total - POS_W'(1));
  assign frame_end  = (v_cnt == v_total - POS_W'(1));
  assign in_win     = (div_cnt >= win_lo) && (div_cnt <= win_hi);

  assign pix_req = run & in_h & in_v & slot_first;
  assign pix_x   = SZ_W'(h_cnt - h_act_beg);
  assign pix_y   = SZ_W'(v_cnt - v_act_beg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run      <= 1'b0;
      dly_cnt  <= '0;
      div_cnt  <= '0;
      h_cnt    <= '0;
      v_cnt    <= '0;
      pix_hold <= '0;
      rgb_q    <= '0;
      hs_q     <= 1'b0;
      vs_q     <= 1'b0;
      de_q     <= 1'b0;
      pclk_q   <= 1'b0;
      cs_q     <= 1'b0;
      fs_q     <= 1'b0;
    end else begin
      hs_q   <= enable & run & (h_cnt < h_sy_end);
      vs_q   <= enable & run & (v_cnt < v_sy_end);
      de_q   <= enable & run & in_h & in_v;
      pclk_q <= enable & run & (div_cnt >= half);
      cs_q   <= enable & run;
      fs_q   <= enable & run & (h_cnt == '0) & (v_cnt == '0) & slot_first;
      rgb_q  <= (enable & run & in_h & in_v & in_win) ? (slot_first ? rgb_in : pix_hold) : '0;
      if (pix_req) pix_hold <= rgb_in;

      if (!enable) begin
        run     <= 1'b0;
        dly_cnt <= '0;
        div_cnt <= '0;
        h_cnt   <= '0;
        v_cnt   <= '0;
      end else if (!run) begin
        if (dly_cnt == start_pos) run <= 1'b1;
        else dly_cnt <= dly_cnt + CNT_W'(1);
      end else if (slot_end) begin
        div_cnt <= '0;
        if (line_end) begin
          h_cnt <= '0;
          v_cnt <= frame_end ? '0 : v_cnt + POS_W'(1);
        end else begin
          h_cnt <= h_cnt + POS_W'(1);
        end
      end else begin
        div_cnt <= div_cnt + CNT_W'(1);
      end
    end
  end

  assign hsync       = hs_q ~^ pol[0];
  assign vsync       = vs_q ~^ pol[1];
  assign de          = de_q ~^ pol[2];
  assign pclk        = pclk_q ~^ pol[3];
  assign cs          = cs_q ~^ pol[4];
  assign frame_start = fs_q;
  assign rgb_out     = rgb_q;

  a_r1_idle_after_disable: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!cs_q && !de_q && !pclk_q && !fs_q && rgb_out == '0));

  a_r7_req_then_de: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_req && enable) |=> de_q);

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    fs_q |=> !fs_q);

  a_r10_in_sync: assert property (@(posedge clk) disable iff (!rst_n)
    fs_q |-> (vs_q && hs_q));

  a_r8_data_in_de: assert property (@(posedge clk) disable iff (!rst_n)
    (rgb_q != '0) |-> de_q);

  a_r11_cs_covers: assert property (@(posedge clk) disable iff (!rst_n)
    (de_q || hs_q || vs_q || pclk_q) |-> cs_q);
endmodule

// File: tb/sim_tft_timing_gen.sv
module sim_tft_timing_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [9:0]  h_act_m1, v_act_m1;
  logic [7:0]  h_fp, h_bp, v_fp, v_bp;
  logic [6:0]  h_sync_m1, v_sync_m1;
  logic [10:0] period, start_pos;
  logic [1:0]  setup_cyc, hold_cyc;
  logic [4:0]  pol;
  logic [15:0] rgb_in;
  logic        pix_req, hsync, vsync, de, pclk, cs, frame_start;
  logic [9:0]  pix_x, pix_y;
  logic [15:0] rgb_out;

  int checks = 0;
  int fails = 0;
  int e = 0;
  bit done = 1'b0;
  string ph = "";

  always #10 clk = ~clk;

  function automatic logic [15:0] pixf(int x, int y);
    logic [7:0] a, b;
    a = 8'(x) ^ 8'h5A;
    b = 8'(y) + 8'h21;
    return {a, b};
  endfunction

  assign rgb_in = pixf(int'(pix_x), int'(pix_y));

  tft_timing_gen u0 (
    .clk(clk), .rst_n(rst_n), .enable(en),
    .h_act_m1(h_act_m1), .v_act_m1(v_act_m1),
    .h_fp(h_fp), .h_bp(h_bp), .v_fp(v_fp), .v_bp(v_bp),
    .h_sync_m1(h_sync_m1), .v_sync_m1(v_sync_m1),
    .period(period), .start_pos(start_pos),
    .setup_cyc(setup_cyc), .hold_cyc(hold_cyc),
    .pol(pol), .rgb_in(rgb_in),
    .pix_req(pix_req), .pix_x(pix_x), .pix_y(pix_y),
    .hsync(hsync), .vsync(vsync), .de(de), .pclk(pclk), .cs(cs),
    .frame_start(frame_start), .rgb_out(rgb_out)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, ph, act, exp);
    end
  endtask

  function automatic int lvl(bit raw, logic p);
    return (p ? raw : !raw) ? 1 : 0;
  endfunction

  task automatic compare();
    int L, E, lo, hi, hs, ha0, ha1, H, vs, va0, va1, V, sp, t, d, slot, h, v;
    bit req, hs_r, vs_r, de_r, pc_r, cs_r, fs_r;
    int rgb;
    L = (int'(period) < 2) ? 2 : int'(period);
    E = L / 2;
    lo = E - int'(setup_cyc); if (lo < 0) lo = 0;
    hi = E + int'(hold_cyc);  if (hi > L - 1) hi = L - 1;
    hs = int'(h_sync_m1) + 1; ha0 = hs + int'(h_bp); ha1 = ha0 + int'(h_act_m1) + 1; H = ha1 + int'(h_fp);
    vs = int'(v_sync_m1) + 1; va0 = vs + int'(v_bp); va1 = va0 + int'(v_act_m1) + 1; V = va1 + int'(v_fp);
    sp = int'(start_pos);
    req = 0; h = 0; v = 0;
    t = e - sp - 1;
    if (e >= sp + 1) begin
      d = t % L; slot = t / L; h = slot % H; v = (slot / H) % V;
      req = (d == 0) && h >= ha0 && h < ha1 && v >= va0 && v < va1;
    end
    chk("R7 pix_req", int'(pix_req), int'(req));
    if (req) begin
      chk("R7 pix_x", int'(pix_x), h - ha0);
      chk("R7 pix_y", int'(pix_y), v - va0);
    end
    {hs_r, vs_r, de_r, pc_r, cs_r, fs_r} = '0;
    rgb = 0;
    t = e - sp - 2;
    if (t >= 0) begin
      d = t % L; slot = t / L; h = slot % H; v = (slot / H) % V;
      hs_r = h < hs;
      vs_r = v < vs;
      de_r = h >= ha0 && h < ha1 && v >= va0 && v < va1;
      pc_r = d >= E;
      cs_r = 1;
      fs_r = (h == 0) && (v == 0) && (d == 0);
      if (de_r && d >= lo && d <= hi) rgb = int'(pixf(h - ha0, v - va0));
    end
    chk("R4 R9 hsync", int'(hsync), lvl(hs_r, pol[0]));
    chk("R5 R9 vsync", int'(vsync), lvl(vs_r, pol[1]));
    chk("R6 R9 de", int'(de), lvl(de_r, pol[2]));
    chk("R3 R9 pclk", int'(pclk), lvl(pc_r, pol[3]));
    chk("R11 R9 cs", int'(cs), lvl(cs_r, pol[4]));
    chk("R10 frame_start", int'(frame_start), int'(fs_r));
    chk("R8 rgb_out", int'(rgb_out), rgb);
  endtask

  task automatic cycles(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      if (!rst_n || !en) e = 0; else e++;
      @(negedge clk);
      compare();
    end
  endtask

  initial begin
    h_act_m1 = 10'd3; h_fp = 8'd1; h_bp = 8'd2; h_sync_m1 = 7'd1;
    v_act_m1 = 10'd2; v_fp = 8'd1; v_bp = 8'd1; v_sync_m1 = 7'd0;
    period = 11'd4; start_pos = 11'd0; setup_cyc = 2'd1; hold_cyc = 2'd1;
    pol = 5'b11111;
    ph = "R1";
    cycles(3);
    rst_n = 1'b1;
    cycles(3);
    en = 1'b1; ph = "R2";
    cycles(10);
    ph = "";
    cycles(460);

    en = 1'b0; ph = "R12";
    cycles(5);
    h_act_m1 = 10'd2; h_fp = 8'd2; h_bp = 8'd1; h_sync_m1 = 7'd0;
    v_act_m1 = 10'd1; v_fp = 8'd0; v_bp = 8'd2; v_sync_m1 = 7'd1;
    period = 11'd7; start_pos = 11'd5; setup_cyc = 2'd3; hold_cyc = 2'd3;
    pol = 5'b01010;
    cycles(2);
    en = 1'b1; ph = "R2";
    cycles(12);
    ph = "";
    cycles(700);

    en = 1'b0; ph = "R1";
    cycles(4);
    h_act_m1 = 10'd0; h_fp = 8'd0; h_bp = 8'd0; h_sync_m1 = 7'd0;
    v_act_m1 = 10'd0; v_fp = 8'd0; v_bp = 8'd0; v_sync_m1 = 7'd0;
    period = 11'd0; start_pos = 11'd1; setup_cyc = 2'd0; hold_cyc = 2'd0;
    pol = 5'b10101;
    en = 1'b1; ph = "R3";
    cycles(40);
    period = 11'd1;
    en = 1'b0; cycles(2); en = 1'b1;
    cycles(30);

    en = 1'b0; ph = "R12";
    cycles(3);
    h_act_m1 = 10'd3; h_fp = 8'd1; h_bp = 8'd2; h_sync_m1 = 7'd1;
    v_act_m1 = 10'd2; v_fp = 8'd1; v_bp = 8'd1; v_sync_m1 = 7'd0;
    period = 11'd5; start_pos = 11'd2; setup_cyc = 2'd1; hold_cyc = 2'd3;
    pol = 5'b00000;
    en = 1'b1;
    cycles(150);
    en = 1'b0;
    cycles(3);
    en = 1'b1;
    cycles(320);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule